// File: doc/BRIEF.md
# Byte-Wide UV-Erasable Programmable Memory Model

This block is a synthesizable, clocked stand-in for a byte-wide ultraviolet-erasable programmable memory. It is meant as a test target for programmer and boot logic. A small parameterised array replaces the full memory. Analog levels become two digital flags. `vpp_hi` says the programming supply is present, and `a9_hv` says the high identifier voltage is on the upper address pin. Each cycle the model decodes the active-low `ce_n` and `oe_n` together with these two flags into one of seven operating modes.

The three-state data bus is split into `dq_in`, `dq_out` and `dq_oe`, and `dq_oe` = 1 means the model drives the bus. Every output is registered, so a result appears one clock after the inputs that select it. A programming state machine measures each chip-enable pulse. When a pulse of sufficient length ends, it clears bits in the addressed byte. `erase` restores every bit to 1.

The state machine has three states:
- `PG_IDLE` waits for the program condition and moves to `PG_PULSE` when it is seen.
- `PG_PULSE` counts the cycles in which the condition holds. When the condition ends, it moves to `PG_WRITE` if the count reached `MIN_PULSE`, or else back to `PG_IDLE` (the reject path).
- `PG_WRITE` commits one write and returns to `PG_IDLE`.

The seven decoded modes are `MD_READ`, `MD_ODIS`, `MD_STBY`, `MD_PROG`, `MD_INHIB`, `MD_VERIFY` and `MD_SIG`.

Top module: `eprom_model`

## Requirements
- R1: Read. When `vpp_hi`=0, `a9_hv`=0, `ce_n`=0 and `oe_n`=0, the model drives `dq_oe`=1 and `dq_out`= the stored byte at `addr`.
- R2: When `vpp_hi`=0, the bus is undriven (`dq_oe`=0) in two cases. The first is `ce_n`=1 (standby), whatever `oe_n` and `a9_hv` are. The second is `ce_n`=0 with `oe_n`=1 (output disable).
- R3: Program. With `vpp_hi`=1, `ce_n`=0 and `oe_n`=1, the model captures `addr` and `dq_in` in the first low cycle. While the pulse lasts, `dq_oe`=0. If the pulse is accepted, the write is committed in the cycle after `ce_n` returns high.
- R4: Verify. With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0, the model drives `dq_oe`=1 with the stored byte at `addr`.
- R5: Inhibit. With `vpp_hi`=1 and both enables high, the bus is undriven and nothing is written. With `vpp_hi`=1 and both enables low, the bus is also undriven.
- R6: Identifier. With `vpp_hi`=0, `a9_hv`=1 and both enables low, an `addr` of 0 returns 0x97 and an `addr` of 1 returns 0x50, each with `dq_oe`=1.
- R7: In identifier mode, if any address bit above bit 0 is 1, the model returns 0xFF with `dq_oe`=1 and raises `proto_err`=1.
- R8: An accepted write stores the old byte ANDed with `dq_in`, so programming can only clear bits.
- R9: A program pulse whose low time covers fewer than `MIN_PULSE` rising clock edges (default 4) leaves the array unchanged.
- R10: One cycle of `erase`=1 sets every bit of every location to 1. Reset also leaves the array erased.
- R11: Outputs are registered one cycle after their inputs. When undriven, `dq_out`=0x00. `proto_err` is 0 outside R7. During reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | High identifier voltage on upper address pin |
| erase | input | 1 | Set every bit to 1 |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data bus as seen by the model (program data) |
| dq_out | output | 8 | Data the model places on the bus |
| dq_oe | output | 1 | 1 = model drives the bus |
| proto_err | output | 1 | Identifier read with a nonzero upper address |

## Verification
Mode results (`dq_oe`, `dq_out`, `proto_err`) are due one rising edge after the inputs change. The bench therefore drives each vector on a falling edge and samples on the next falling edge. An array write lands two edges after the first high sample of `ce_n`. Program pulses are timed by counting rising edges while the enable is held low. After each pulse the bench waits three cycles before verifying, so that every write result is read only after its commit edge.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MD_READ,
        MD_ODIS,
        MD_STBY,
        MD_PROG,
        MD_INHIB,
        MD_VERIFY,
        MD_SIG
    } mode_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_PULSE,
        PG_WRITE
    } pg_state_e;

    localparam logic [7:0] SIG_MFG = 8'h97;
    localparam logic [7:0] SIG_DEV = 8'h50;
    localparam logic [7:0] ERASED  = 8'hFF;
    localparam logic [7:0] UNDRIVEN = 8'h00;

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
    import eprom_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  a9_hv,
    output mode_e mode
);

    always_comb begin
        if (vpp_hi) begin
            unique case ({ce_n, oe_n})
                2'b01:   mode = MD_PROG;
                2'b10:   mode = MD_VERIFY;
                2'b11:   mode = MD_INHIB;
                default: mode = MD_INHIB;
            endcase
        end else if (ce_n) begin
            mode = MD_STBY;
        end else if (oe_n) begin
            mode = MD_ODIS;
        end else if (a9_hv) begin
            mode = MD_SIG;
        end else begin
            mode = MD_READ;
        end
    end

endmodule

// File: rtl/eprom_prog_fsm.sv
module eprom_prog_fsm
    import eprom_pkg::*;
#(
    parameter int AW        = 4,
    parameter int MIN_PULSE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_req,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_PULSE);

    pg_state_e state, state_nx;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PG_IDLE;
        else        state <= state_nx;
    end

    // pulse counter and capture of address and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            wr_addr <= '0;
            wr_data <= ERASED;
        end else if (state == PG_IDLE && prog_req) begin
            cnt     <= CW'(1);
            wr_addr <= addr;
            wr_data <= din;
        end else if (state == PG_PULSE && prog_req && cnt != CNT_MAX) begin
            cnt <= cnt + CW'(1);
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            PG_IDLE:  if (prog_req) state_nx = PG_PULSE;
            PG_PULSE: begin
                if (!prog_req) state_nx = (cnt >= CNT_MAX) ? PG_WRITE : PG_IDLE;
            end
            PG_WRITE: state_nx = PG_IDLE;
            default:  state_nx = PG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en = (state == PG_WRITE);
    end

endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int MIN_PULSE = 4,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          vpp_hi,
    input  logic          a9_hv,
    input  logic          erase,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    output logic          proto_err
);

    mode_e         mode;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic          sig_ok;

    eprom_mode_decode u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    eprom_prog_fsm #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_req (mode == MD_PROG),
        .addr     (addr),
        .din      (dq_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    eprom_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    always_comb begin
        sig_ok = (addr[AW-1:1] == '0);
    end

    // registered bus stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out    <= UNDRIVEN;
            dq_oe     <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            dq_out    <= UNDRIVEN;
            dq_oe     <= 1'b0;
            proto_err <= 1'b0;
            unique case (mode)
                MD_READ, MD_VERIFY: begin
                    dq_out <= rd_data;
                    dq_oe  <= 1'b1;
                end
                MD_SIG: begin
                    dq_oe <= 1'b1;
                    if (!sig_ok) begin
                        dq_out    <= ERASED;
                        proto_err <= 1'b1;
                    end else begin
                        dq_out <= addr[0] ? SIG_DEV : SIG_MFG;
                    end
                end
                MD_ODIS, MD_STBY, MD_PROG, MD_INHIB: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int AW        = 4,
    parameter int MIN_PULSE = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          vpp_hi,
    input logic          a9_hv,
    input logic [AW-1:0] addr,
    input logic [7:0]    dq_out,
    input logic          dq_oe,
    input logic          proto_err,
    input logic          wr_en
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(MIN_PULSE);

    logic [CW-1:0] run;
    logic [CW-1:0] last_len;
    logic          prog_seen;

    always_comb prog_seen = vpp_hi && !ce_n && oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= '0;
            last_len <= '0;
        end else if (prog_seen) begin
            if (run != RUN_MAX) run <= run + CW'(1);
        end else begin
            last_len <= run;
            run      <= '0;
        end
    end

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) && !$past(vpp_hi)) |-> !dq_oe); // R2

    AST_ODIS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(vpp_hi) && !$past(ce_n) && $past(oe_n)) |-> !dq_oe); // R2

    AST_PROG_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        prog_seen |=> !dq_oe); // R3

    AST_SIG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vpp_hi) && $past(a9_hv) && !$past(ce_n) && !$past(oe_n)
         && ($past(addr) == AW'(1))) |-> (dq_oe && dq_out == 8'h50)); // R6

    AST_SIG_ERR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (dq_oe && dq_out == 8'hFF)); // R7

    AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (last_len >= RUN_MAX)); // R9

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == 8'h00 && !proto_err)); // R11

endmodule

bind eprom_model eprom_model_chk #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_chk (.*);

// File: tb/eprom_model_tb.sv
module eprom_model_tb;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int NV    = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = 8'hFF;
    logic [7:0]    dq_out;
    logic          dq_oe;
    logic          proto_err;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    eprom_model #(.DEPTH(DEPTH), .MIN_PULSE(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .erase(erase), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .proto_err(proto_err)
    );

    // {vpp, a9, ce_n, oe_n, addr, exp_oe, exp_dq, exp_err}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'h3, 1'b1, 8'hFF, 1'b0}, // R1 erased read
        {1'b0, 1'b0, 1'b0, 1'b1, 4'h3, 1'b0, 8'h00, 1'b0}, // R2 output disable
        {1'b0, 1'b0, 1'b1, 1'b0, 4'h3, 1'b0, 8'h00, 1'b0}, // R2 standby
        {1'b0, 1'b0, 1'b1, 1'b1, 4'h7, 1'b0, 8'h00, 1'b0}, // R2 standby
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 8'h97, 1'b0}, // R6 maker code
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h1, 1'b1, 8'h50, 1'b0}, // R6 device code
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h2, 1'b1, 8'hFF, 1'b1}, // R7 bad address
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h9, 1'b1, 8'hFF, 1'b1}, // R7 bad address
        {1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, 1'b0}, // R2 standby with a9
        {1'b1, 1'b0, 1'b1, 1'b0, 4'h5, 1'b1, 8'hFF, 1'b0}, // R4 verify erased
        {1'b1, 1'b0, 1'b1, 1'b1, 4'h5, 1'b0, 8'h00, 1'b0}, // R5 inhibit
        {1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 1'b0, 8'h00, 1'b0}, // R5 both low
        {1'b1, 1'b0, 1'b0, 1'b1, 4'h5, 1'b0, 8'h00, 1'b0}  // R3 program hi-z
    };

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual oe/dq/err=%b/%h/%b expected %b/%h/%b",
                     tag, act[9], act[8:1], act[0], exp[9], exp[8:1], exp[0]);
        end
    endtask

    task automatic look(input logic v, input logic a9, input logic c, input logic o,
                        input logic [AW-1:0] ad);
        @(negedge clk);
        vpp_hi = v; a9_hv = a9; ce_n = c; oe_n = o; addr = ad;
        @(negedge clk);
    endtask

    task automatic prog(input logic [AW-1:0] ad, input logic [7:0] d, input int ncyc);
        @(negedge clk);
        vpp_hi = 1'b1; a9_hv = 1'b0; ce_n = 1'b1; oe_n = 1'b1; addr = ad; dq_in = d;
        @(negedge clk);
        ce_n = 1'b0;
        for (int k = 0; k < ncyc; k++) @(negedge clk);
        chk("R3 bus during pulse", {dq_oe, dq_out, proto_err}, {1'b0, 8'h00, 1'b0});
        ce_n = 1'b1;
        dq_in = 8'hFF;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL R11 watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", {dq_oe, dq_out, proto_err}, {1'b0, 8'h00, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {vpp_hi, a9_hv, ce_n, oe_n, addr} = VEC[i][17:10];
            @(negedge clk);
            chk($sformatf("vector %0d (R1/R2/R4/R5/R6/R7 table)", i),
                {dq_oe, dq_out, proto_err}, VEC[i][9:0]);
        end

        // R9: pulse one edge short
        prog(4'h2, 8'h0F, 3);
        look(1'b1, 1'b0, 1'b1, 1'b0, 4'h2);
        chk("R9 short pulse ignored", {dq_oe, dq_out, proto_err}, {1'b1, 8'hFF, 1'b0});

        // R3 / R4: pulse of exactly MIN_PULSE edges
        prog(4'h2, 8'h3C, 4);
        look(1'b1, 1'b0, 1'b1, 1'b0, 4'h2);
        chk("R3 R4 program then verify", {dq_oe, dq_out, proto_err}, {1'b1, 8'h3C, 1'b0});

        // R8: second write only clears bits
        prog(4'h2, 8'hF0, 6);
        look(1'b1, 1'b0, 1'b1, 1'b0, 4'h2);
        chk("R8 AND of old and new", {dq_oe, dq_out, proto_err}, {1'b1, 8'h30, 1'b0});

        // R1: normal read of the programmed byte, neighbour untouched
        look(1'b0, 1'b0, 1'b0, 1'b0, 4'h2);
        chk("R1 read programmed", {dq_oe, dq_out, proto_err}, {1'b1, 8'h30, 1'b0});
        look(1'b0, 1'b0, 1'b0, 1'b0, 4'h3);
        chk("R1 neighbour unchanged", {dq_oe, dq_out, proto_err}, {1'b1, 8'hFF, 1'b0});

        // R5: inhibit state with data on the bus writes nothing
        @(negedge clk);
        vpp_hi = 1'b1; ce_n = 1'b1; oe_n = 1'b1; addr = 4'h2; dq_in = 8'h00;
        repeat (6) @(negedge clk);
        dq_in = 8'hFF;
        look(1'b1, 1'b0, 1'b1, 1'b0, 4'h2);
        chk("R5 inhibit no write", {dq_oe, dq_out, proto_err}, {1'b1, 8'h30, 1'b0});

        // R10: erase
        @(negedge clk);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        look(1'b0, 1'b0, 1'b0, 1'b0, 4'h2);
        chk("R10 erase restores ones", {dq_oe, dq_out, proto_err}, {1'b1, 8'hFF, 1'b0});

        // R11: one-cycle latency, first sample after a change is due at the next edge
        @(negedge clk);
        vpp_hi = 1'b0; a9_hv = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = 4'h0;
        #1;
        chk("R11 output not yet updated", {dq_oe, dq_out, proto_err}, {1'b1, 8'hFF, 1'b0});
        @(negedge clk);
        chk("R11 output after one edge", {dq_oe, dq_out, proto_err}, {1'b1, 8'h97, 1'b0});

        look(1'b0, 1'b0, 1'b1, 1'b1, 4'h0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule